// File: doc/BRIEF.md
# Programmable Baud Divisor

The block divides its input clock by a 16-bit programmable divisor to produce the 16x oversampling clock for a serial port. It also produces a one-cycle tick at the end of each period, which logic in the same clock domain can use as a baud enable. The divisor lives in byte-wide latches. Each latch has its own write strobe and shares one data byte. The full divisor can be read back.

The period is set by the divisor, and so is the shape of the output. A divisor of three or more gives a pulse that is low for two input cycles and high for the rest of the period. A divisor of 2 gives a square wave. A divisor of 1 passes the inverted input clock straight through. A divisor of 0 behaves like divide-by-3.

Any latch write restarts the count from the new divisor on the next cycle. A long count left over from an old divisor is never waited out.

Top module: `baud_div_top`

In the requirements, "phase 0" is the first clock cycle after the edge that reloads the counter. Phases then run 0, 1, …, P−1, where P is the period.

## Requirements
- R1: A write with `lane_we[0]` loads `wr_data` into `div_rd[7:0]`, and a write with `lane_we[1]` loads it into `div_rd[15:8]`. The new value is visible in the cycle after the write edge. The other byte is unchanged.
- R2: Any write, to either byte, starts a new period at phase 0 in the cycle after the write edge. This holds no matter how far the old count had progressed.
- R3: With divisor 0 the period is 3 cycles: low in phases 0 and 1, high in phase 2.
- R4: With divisor 1, `baud_out` is the inverse of `clk`: 0 while `clk` is high and 1 while it is low. `baud_tick` is 1 in every cycle.
- R5: With divisor 2 the period is 2 cycles: low in phase 0 and high in phase 1, a 50% duty cycle.
- R6: With a divisor N of 3 or more the period is N cycles: low in phases 0 and 1, high in phases 2 to N−1.
- R7: `baud_tick` is 1 only in the last phase of each period, for one cycle per period.
- R8: While `rst_n` is low at a clock edge, `div_rd` is 0, `baud_out` is 0, `baud_tick` is 0 and the count is held at phase 0 of the divisor-0 pattern. The first cycle after reset is released is phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_we | input | 2 | Per-byte write strobes, bit 0 for the low byte |
| wr_data | input | 8 | Byte written to each strobed latch |
| div_rd | output | 16 | Current divisor |
| baud_out | output | 1 | Divided output waveform |
| baud_tick | output | 1 | One-cycle pulse in the last phase of each period |

## Verification
The assertions assume that the strobes and the data are stable around each rising clock edge. They also assume that `clk` runs with a roughly even duty cycle, because in divisor-1 mode `clk` itself reaches the output. The bench meets both assumptions by changing inputs only near falling edges and by clearing the strobes well before the next rising edge. It samples `baud_out` shortly after each rising edge. In divisor-1 mode it also samples shortly after the falling edge, so that both clock levels are observed.

// File: rtl/baud_div_pkg.sv
// Shared types for the baud divisor.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package baud_div_pkg;

    // Waveform class selected by the divisor value.
    typedef enum logic [1:0] {
        BM_DIV3   = 2'd0,   // divisor 0, treated as a period of three
        BM_INVERT = 2'd1,   // divisor 1, inverted input clock
        BM_HALF   = 2'd2,   // divisor 2, square wave
        BM_PULSE  = 2'd3    // divisor 3 or more, two low cycles per period
    } baud_mode_e;

endpackage

// File: rtl/baud_div_regs.sv
// Divisor byte latches.
// Each lane strobe loads the shared data byte into its own slice.
// Also exposes the next-state divisor and the waveform class of that value.
// Assumes DIV_W is a whole multiple of BYTE_W.
module baud_div_regs
    import baud_div_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int LANES  = DIV_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_nxt,
    output logic              any_we,
    output baud_mode_e        mode_q,
    output baud_mode_e        mode_nxt
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    // Next value for each byte slice: the written byte, or the held byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign div_nxt[g*BYTE_W +: BYTE_W] = lane_we[g] ? wr_data
                                                        : div_q[g*BYTE_W +: BYTE_W];

        AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            lane_we[g] |=> div_q[g*BYTE_W +: BYTE_W] == $past(wr_data)); // R1
    end

    assign any_we = |lane_we;

    // Work out the waveform class of the divisor in force next cycle.
    always_comb begin
        if (div_nxt == '0)       mode_nxt = BM_DIV3;
        else if (div_nxt == ONE) mode_nxt = BM_INVERT;
        else if (div_nxt == TWO) mode_nxt = BM_HALF;
        else                     mode_nxt = BM_PULSE;
    end

    // Hold the divisor and its class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            mode_q <= BM_DIV3;
        end else begin
            div_q  <= div_nxt;
            mode_q <= mode_nxt;
        end
    end

endmodule

// File: rtl/baud_div_count.sv
// Period down-counter.
// Counts from the effective divisor down to 1, then reloads.
// Any latch write forces an immediate reload with the new value.
// Divisor 0 is taken as 3.
// Assumes div_nxt equals div_q in every cycle without a write.
module baud_div_count #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_q,
    input  logic [DIV_W-1:0] div_nxt,
    output logic [DIV_W-1:0] cnt_q,
    output logic [DIV_W-1:0] cnt_d,
    output logic [DIV_W-1:0] eff_q,
    output logic [DIV_W-1:0] eff_d,
    output logic             last
);

    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
    localparam logic [DIV_W-1:0] THREE = DIV_W'(3);

    function automatic logic [DIV_W-1:0] eff_of(input logic [DIV_W-1:0] d);
        return (d == '0) ? THREE : d;
    endfunction

    assign eff_q = eff_of(div_q);
    assign eff_d = eff_of(div_nxt);
    assign last  = (cnt_q == ONE);

    // Choose the next count: reload on a write or at the end of a period.
    always_comb begin
        if (reload || last) cnt_d = eff_d;
        else                cnt_d = cnt_q - ONE;
    end

    // Count register; reset starts at the divisor-0 reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= THREE;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= eff_q)); // R6

    AST_RELOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt_q == eff_q); // R2

    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !reload) |=> cnt_q == eff_q); // R7

endmodule

// File: rtl/baud_div_shape.sv
// Output waveform shaper.
// Registers the output level from the next count, so the output does not glitch.
// In the inverted-clock class it selects the inverted input clock instead.
// Assumes cnt_d and eff_d are the count and effective divisor of the next cycle.
module baud_div_shape
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  baud_mode_e       mode_q,
    input  baud_mode_e       mode_nxt,
    input  logic [DIV_W-1:0] cnt_q,
    input  logic [DIV_W-1:0] cnt_d,
    input  logic [DIV_W-1:0] eff_q,
    input  logic [DIV_W-1:0] eff_d,
    output logic             baud_out
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    logic low_d;
    logic out_q;

    // Decide whether the next cycle belongs to the low part of the period.
    always_comb begin
        case (mode_nxt)
            BM_HALF:   low_d = (cnt_d == TWO);
            BM_INVERT: low_d = 1'b0;
            default:   low_d = (cnt_d >= eff_d - ONE);
        endcase
    end

    // Register the output level; it is low during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= !low_d;
    end

    assign baud_out = (mode_q == BM_INVERT) ? ~clk : out_q;

    AST_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == BM_PULSE || mode_q == BM_DIV3) && cnt_q == eff_q) |-> !out_q); // R6

    AST_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == BM_PULSE || mode_q == BM_DIV3) && cnt_q == ONE) |-> out_q); // R6

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BM_HALF && mode_nxt == BM_HALF && !reload) |=> out_q != $past(out_q)); // R5

endmodule

// File: rtl/baud_div_top.sv
// Programmable baud divisor, top level.
// Joins the byte latches, the period counter and the waveform shaper.
// The tick marks the last cycle of each period.
// Assumes a single clock domain and inputs stable at the rising edge.
module baud_div_top
    import baud_div_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int LANES  = DIV_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_rd,
    output logic              baud_out,
    output logic              baud_tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_nxt;
    logic             any_we;
    baud_mode_e       mode_q;
    baud_mode_e       mode_nxt;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_d;
    logic [DIV_W-1:0] eff_q;
    logic [DIV_W-1:0] eff_d;
    logic             last;

    baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_we  (lane_we),
        .wr_data  (wr_data),
        .div_q    (div_q),
        .div_nxt  (div_nxt),
        .any_we   (any_we),
        .mode_q   (mode_q),
        .mode_nxt (mode_nxt)
    );

    baud_div_count #(.DIV_W(DIV_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (any_we),
        .div_q   (div_q),
        .div_nxt (div_nxt),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d),
        .eff_q   (eff_q),
        .eff_d   (eff_d),
        .last    (last)
    );

    baud_div_shape #(.DIV_W(DIV_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (any_we),
        .mode_q   (mode_q),
        .mode_nxt (mode_nxt),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .eff_q    (eff_q),
        .eff_d    (eff_d),
        .baud_out (baud_out)
    );

    assign div_rd    = div_q;
    assign baud_tick = last;

    AST_INV_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BM_INVERT && !any_we) |=> baud_tick); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (div_rd == '0 && !baud_tick)); // R8

endmodule

// File: tb/baud_div_top_tb.sv
// Directed bench for the baud divisor: one task per scenario.
module baud_div_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lane_we = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] div_rd;
    logic        baud_out;
    logic        baud_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    baud_div_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .wr_data   (wr_data),
        .div_rd    (div_rd),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe lanes at a falling edge. Returns 2 ns after the write edge, which is phase 0.
    task automatic wr_lanes(input logic [1:0] we, input logic [7:0] d);
        @(negedge clk);
        lane_we = we;
        wr_data = d;
        @(posedge clk);
        #2;
        lane_we = '0;
    endtask

    task automatic set_div(input logic [15:0] v);
        wr_lanes(2'b10, v[15:8]);
        wr_lanes(2'b01, v[7:0]);
    endtask

    // Compare the waveform with the period model from phase k0 for 'cycles' cycles.
    // All mismatches count as one check.
    task automatic check_wave(input int n, input int k0, input int cycles, input string req);
        int eff = (n == 0) ? 3 : n;
        int bad = 0;
        int a_out = 0, e_out = 0, a_tk = 0, e_tk = 0;
        for (int k = k0; k < k0 + cycles; k++) begin
            int ph = k % eff;
            int eo = (eff == 1) ? 0 : (eff == 2) ? int'(ph != 0) : int'(ph >= 2);
            int et = int'(ph == eff - 1);
            if (int'(baud_out) != eo || int'(baud_tick) != et) begin
                if (bad == 0) begin
                    a_out = baud_out; e_out = eo; a_tk = baud_tick; e_tk = et;
                end
                bad++;
            end
            if (eff == 1) begin
                #5;
                if (baud_out !== 1'b1) begin
                    if (bad == 0) begin
                        a_out = baud_out; e_out = 1; a_tk = baud_tick; e_tk = 1;
                    end
                    bad++;
                end
            end
            if (k < k0 + cycles - 1) begin
                @(posedge clk);
                #2;
            end
        end
        chk(bad == 0, req, $sformatf("wave div %0d out/tick", n),
            (a_out << 4) | a_tk, (e_out << 4) | e_tk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(div_rd == 16'h0, "R1", "div after reset", div_rd, 0);
        chk(baud_out == 1'b0 && baud_tick == 1'b0, "R8", "out/tick in reset",
            {baud_out, baud_tick}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_wave(0, 1, 8, "R8");
    endtask

    task automatic t_div2();
        set_div(16'd2);
        check_wave(2, 0, 8, "R5");
    endtask

    task automatic t_div3_5();
        set_div(16'd3);
        check_wave(3, 0, 9, "R6");
        set_div(16'd5);
        check_wave(5, 0, 15, "R7");
    endtask

    task automatic t_div0();
        set_div(16'd0);
        check_wave(0, 0, 9, "R3");
    endtask

    task automatic t_div1();
        set_div(16'd1);
        check_wave(1, 0, 6, "R4");
    endtask

    task automatic t_lanes();
        set_div(16'd0);
        wr_lanes(2'b01, 8'h34);
        chk(div_rd == 16'h0034, "R1", "low byte only", div_rd, 16'h0034);
        wr_lanes(2'b10, 8'h12);
        chk(div_rd == 16'h1234, "R1", "high byte only", div_rd, 16'h1234);
        check_wave(16'h1234, 0, 16'h1234 + 4, "R6");
    endtask

    task automatic t_midcount();
        set_div(16'd1000);
        check_wave(1000, 0, 12, "R6");
        // The high byte write alone reloads with 0x00E8 = 232.
        wr_lanes(2'b10, 8'h00);
        chk(div_rd == 16'd232, "R2", "div after high write", div_rd, 232);
        check_wave(232, 0, 4, "R2");
        wr_lanes(2'b01, 8'h04);
        check_wave(4, 0, 10, "R2");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_div2();
        t_div3_5();
        t_div0();
        t_div1();
        t_lanes();
        t_midcount();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule